// File: doc/BRIEF.md
# SMBus Block-Transfer Register Slave

This block is a serial register slave that sits on a two-wire open-drain bus and holds twenty-one byte-wide configuration registers. A system clock oversamples the bus clock and data lines; the slave finds START and STOP conditions and bit edges in those samples and pulls the data line low when it acknowledges or sends a zero bit. It answers only two address bytes: 0xD2 selects a write and 0xD3 selects a read.

A write is always a block write. The first two bytes after the address (a command byte and a count byte) are acknowledged and then thrown away. The bytes after them fill registers 0, 1, 2 and onwards in that order, and the master may stop after any whole byte. A read first returns the value of the count register, then registers 0 up to the limit that register sets. Two byte pairs only ever change together, so a multi-byte setting can never be left half-written. All registers are also presented in parallel to the logic around the block.

Top module: `blkreg_slave`

## Requirements
- R1: The slave acknowledges the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the slave then leaves the data line released and ignores every byte until the next START.
- R2: In a write, the slave acknowledges every byte. The first two bytes after the address change nothing. The k-th byte after them (k counted from 0) is written to register k. Bytes that would land above register 20 are acknowledged and dropped. A STOP after any whole byte keeps what was written up to that point.
- R3: A read returns the current value of register 8 first. It then returns registers 0 through min(register 8, 20) in increasing order, and 0xFF for every byte after that. When the master answers a byte with NACK, the slave stops driving the data line at once.
- R4: Register 8 resets to 0x08. A write of 0x00 to it is ignored, so its value is never 0x00.
- R5: Registers 11/12 form one pair and registers 13/14 form another. A pair changes only when both of its bytes are written in the same transfer, and then both bytes change in the same cycle. If a transfer writes only the first byte of a pair, neither byte changes.
- R6: Register 7 cannot be written. It always reads as {3'b001, rev_id_i[4:0]}: the vendor code is in bits 7:5 and the revision is in bits 4:0.
- R7: Registers 5, 19 and 20 store what is written and read back over the bus, but their bytes on regs_o always stay 0x00.
- R8: After reset the data line is released. Registers 1, 2, 3, 4 and 6 hold 0xFF, register 8 holds 0x08, register 9 holds 0x10, and all other stored registers hold 0x00.
- R9: The slave starts pulling the data line low only while the bus clock is low, and it has released the line on the cycle after a detected STOP.
- R10: regs_o carries register i on bits [8*i+7 : 8*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| rev_id_i | input | 5 | Revision code shown in register 7 |
| regs_o | output | 168 | Parallel view of all registers, 8 bits each |

## Verification
The bound checker watches, on every cycle, the rules that can be judged from one moment or from one cycle to the next. The data line is only asserted while the synchronized clock is low and is released after a STOP. The slave stays silent while it is idle, including after a mismatched address. Register 8 never becomes zero. A byte of a pair only changes on the cycle after a write to its second byte. Everything that depends on a whole transfer is shown by the bench's scenarios instead: discarding the command and count bytes, the order in which data bytes fill registers, a pair abandoned halfway, the readback limit and the 0xFF padding beyond it, a read cut short by NACK, and registers that store data without reaching the outputs.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

    localparam int          NREG      = 21;
    localparam int          IDX_W     = $clog2(NREG);
    localparam int          BYTE_W    = 8;
    localparam int          REV_W     = 5;
    localparam int          VID_W     = BYTE_W - REV_W;
    localparam logic [7:0]  ADDR_WR   = 8'hD2;
    localparam logic [7:0]  ADDR_RD   = 8'hD3;
    localparam logic [VID_W-1:0] VENDOR_CODE = 3'b001;
    localparam int          ID_IDX    = 7;
    localparam int          CNT_IDX   = 8;
    localparam int          SKIP_HDR  = 2;
    localparam int          NPAIR     = 2;
    localparam int          PAIR_LO [NPAIR] = '{11, 13};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK,
        ST_WR,
        ST_WR_END,
        ST_RD,
        ST_RD_MACK,
        ST_RD_NEXT
    } bus_state_e;

    function automatic logic [7:0] reg_default(input int i);
        case (i)
            1, 2, 3, 4, 6: return 8'hFF;
            CNT_IDX:       return 8'h08;
            9:             return 8'h10;
            default:       return 8'h00;
        endcase
    endfunction

    function automatic logic is_dead(input int i);
        return (i == 5) || (i == 19) || (i == 20);
    endfunction

    function automatic logic in_pair(input int i);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < NPAIR; p++)
            if (i == PAIR_LO[p] || i == PAIR_LO[p] + 1) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/blkreg_line_sync.sv
module blkreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q    = scl_sh[STAGES-1];
    assign sda_q    = sda_sh[STAGES-1];
    assign scl_rise = scl_q & ~scl_d;
    assign scl_fall = ~scl_q & scl_d;
    assign start_p  = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_p   = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/blkreg_regfile.sv
module blkreg_regfile
    import blkreg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xfer_start,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [REV_W-1:0]       rev_id,
    output logic [7:0]             rd_data,
    output logic [7:0]             cnt_byte,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    logic [7:0]       mem  [NREG];
    logic [7:0]       pend [NPAIR];
    logic [NPAIR-1:0] pend_vld;
    logic [7:0]       id_byte;
    int               wr_int;
    int               lim;

    assign id_byte  = {VENDOR_CODE, rev_id};
    assign wr_int   = int'(wr_idx);
    assign cnt_byte = mem[CNT_IDX];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reg_default(i);
            for (int p = 0; p < NPAIR; p++) pend[p] <= '0;
            pend_vld <= '0;
        end else begin
            if (xfer_start) pend_vld <= '0;
            if (wr_en) begin
                for (int p = 0; p < NPAIR; p++) begin
                    if (wr_int == PAIR_LO[p]) begin
                        pend[p]     <= wr_data;
                        pend_vld[p] <= 1'b1;
                    end else if (wr_int == PAIR_LO[p] + 1 && pend_vld[p]) begin
                        mem[PAIR_LO[p]]     <= pend[p];
                        mem[PAIR_LO[p] + 1] <= wr_data;
                        pend_vld[p]         <= 1'b0;
                    end
                end
                if (!in_pair(wr_int) && wr_int != ID_IDX && wr_int < NREG &&
                    !(wr_int == CNT_IDX && wr_data == 8'h00))
                    mem[wr_idx] <= wr_data;
            end
        end
    end

    always_comb begin
        lim = (int'(mem[CNT_IDX]) > NREG - 1) ? NREG - 1 : int'(mem[CNT_IDX]);
        if (int'(rd_idx) > lim)
            rd_data = 8'hFF;
        else if (int'(rd_idx) == ID_IDX)
            rd_data = id_byte;
        else
            rd_data = mem[rd_idx];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        if (is_dead(g)) begin : g_dead
            assign regs_o[g*BYTE_W +: BYTE_W] = '0;
        end else if (g == ID_IDX) begin : g_id
            assign regs_o[g*BYTE_W +: BYTE_W] = id_byte;
        end else begin : g_live
            assign regs_o[g*BYTE_W +: BYTE_W] = mem[g];
        end
    end
endmodule

// File: rtl/blkreg_slave.sv
module blkreg_slave
    import blkreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [REV_W-1:0]       rev_id_i,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    logic             scl_q, sda_q, scl_rise, scl_fall, start_p, stop_p;
    bus_state_e       state;
    logic [2:0]       bit_cnt;
    logic [7:0]       sh;
    logic [6:0]       tx;
    logic             is_rd;
    logic [7:0]       wr_cnt;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       rd_data, cnt_byte;

    blkreg_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    // data byte k after the two header bytes goes to register k (R2)
    assign wr_en  = (state == ST_WR_END) && scl_fall &&
                    (wr_cnt >= 8'(SKIP_HDR)) && ((wr_cnt - 8'(SKIP_HDR)) < 8'(NREG));
    assign wr_idx = wr_cnt[IDX_W-1:0] - IDX_W'(SKIP_HDR);

    blkreg_regfile regs_i (
        .clk(clk), .rst(rst), .xfer_start(start_p), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(sh), .rd_idx(rd_idx), .rev_id(rev_id_i),
        .rd_data(rd_data), .cnt_byte(cnt_byte), .regs_o(regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            sh       <= '0;
            tx       <= '0;
            is_rd    <= 1'b0;
            wr_cnt   <= '0;
            rd_idx   <= '0;
        end else if (start_p) begin
            state    <= ST_ADDR;
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            wr_cnt   <= '0;
        end else if (stop_p) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WR: if (scl_rise) begin
                    sh      <= {sh[6:0], sda_q};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7)
                        state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
                end
                ST_ADDR_END: if (scl_fall) begin
                    if (sh == ADDR_WR || sh == ADDR_RD) begin
                        sda_oe_o <= 1'b1;
                        is_rd    <= (sh == ADDR_RD);
                        state    <= ST_ACK;
                    end else begin
                        state    <= ST_IDLE;
                    end
                end
                ST_WR_END: if (scl_fall) begin
                    sda_oe_o <= 1'b1;
                    if (wr_cnt != 8'hFF) wr_cnt <= wr_cnt + 8'd1;
                    state    <= ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (is_rd) begin
                        sda_oe_o <= ~cnt_byte[7];
                        tx       <= cnt_byte[6:0];
                        rd_idx   <= '0;
                        state    <= ST_RD;
                    end else begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_WR;
                    end
                end
                ST_RD: if (scl_fall) begin
                    if (bit_cnt == 3'd7) begin
                        sda_oe_o <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_RD_MACK;
                    end else begin
                        sda_oe_o <= ~tx[6];
                        tx       <= {tx[5:0], 1'b1};
                        bit_cnt  <= bit_cnt + 3'd1;
                    end
                end
                ST_RD_MACK: if (scl_rise) begin
                    state <= sda_q ? ST_IDLE : ST_RD_NEXT;
                end
                ST_RD_NEXT: if (scl_fall) begin
                    sda_oe_o <= ~rd_data[7];
                    tx       <= rd_data[6:0];
                    bit_cnt  <= '0;
                    if (rd_idx != '1) rd_idx <= rd_idx + IDX_W'(1);
                    state    <= ST_RD;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/blkreg_checker.sv
module blkreg_checker
    import blkreg_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_q,
    input logic                   stop_p,
    input logic                   sda_oe_o,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx,
    input bus_state_e             state,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_q);

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !sda_oe_o);

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        regs_o[CNT_IDX*BYTE_W +: BYTE_W] != 8'h00);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = PAIR_LO[p];
        assert_pair_commit_R5: assert property (@(posedge clk) disable iff (rst)
            !$stable(regs_o[LO*BYTE_W +: BYTE_W]) |->
                $past(wr_en && int'(wr_idx) == LO + 1));
    end
endmodule

bind blkreg_slave blkreg_checker chk_i (
    .clk(clk), .rst(rst), .scl_q(scl_q), .stop_p(stop_p), .sda_oe_o(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .state(state), .regs_o(regs_o)
);

// File: tb/blkreg_slave_tb_top.sv
module blkreg_slave_tb_top;
    import blkreg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   scl_m = 1'b1;
    logic                   sda_m = 1'b1;
    logic                   sda_oe;
    logic [REV_W-1:0]       rev = 5'h0A;
    logic [NREG*BYTE_W-1:0] regs;
    logic                   sda_line;

    assign sda_line = sda_m & ~sda_oe;

    blkreg_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .rev_id_i(rev), .regs_o(regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_chk  = 0;
    int         n_fail = 0;
    logic [7:0] m   [NREG];
    logic [7:0] pat [24];

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] id_val();
        return {3'b001, rev};
    endfunction

    function automatic logic [7:0] exp_out(input int i);
        if (i == 5 || i == 19 || i == 20) return 8'h00;
        if (i == 7) return id_val();
        return m[i];
    endfunction

    function automatic logic [7:0] exp_rd(input int k);
        int lim;
        lim = (int'(m[8]) > 20) ? 20 : int'(m[8]);
        if (k > lim) return 8'hFF;
        if (k == 7) return id_val();
        return m[k];
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, $sformatf("regs_o byte %0d", i), regs[i*8 +: 8], exp_out(i));
    endtask

    task automatic model_write(input int n);
        for (int k = 0; k < n && k < NREG; k++) begin
            if (k == 7 || k == 11 || k == 13) continue;
            if (k == 8 && pat[k] == 8'h00) continue;
            if (k == 12 || k == 14) m[k-1] = pat[k-1];
            m[k] = pat[k];
        end
    endtask

    task automatic start_c();
        sda_m = 1'b1; hw(HALF);
        scl_m = 1'b1; hw(HALF);
        sda_m = 1'b0; hw(HALF);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; hw(HALF);
        scl_m = 1'b1; hw(HALF);
        sda_m = 1'b1; hw(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(HALF);
            scl_m = 1'b1; hw(HALF);
            scl_m = 1'b0; hw(2);
        end
        sda_m = 1'b1; hw(HALF);
        scl_m = 1'b1; hw(HALF/2);
        acked = (sda_line == 1'b0);
        hw(HALF/2);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(HALF);
            scl_m = 1'b1; hw(HALF/2);
            b[i] = sda_line;
            hw(HALF/2);
            scl_m = 1'b0; hw(2);
        end
        sda_m = ~ack; hw(HALF);
        scl_m = 1'b1; hw(HALF);
        scl_m = 1'b0; hw(2);
        sda_m = 1'b1;
    endtask

    task automatic wr_xfer(input int n, input string req);
        logic a, all_ack;
        start_c();
        send_byte(ADDR_WR, a);
        chk("R1", "write address ack", {7'd0, a}, 8'd1);
        all_ack = 1'b1;
        send_byte(8'h5A, a); all_ack &= a;   // command byte, discarded
        send_byte(8'(n), a); all_ack &= a;   // count byte, discarded
        for (int k = 0; k < n; k++) begin
            send_byte(pat[k], a);
            all_ack &= a;
        end
        stop_c();
        hw(4);
        chk("R2", "all write bytes acked", {7'd0, all_ack}, 8'd1);
        model_write(n);
        check_regs(req);
    endtask

    task automatic rd_xfer(input int n, input string req);
        logic       a;
        logic [7:0] b;
        start_c();
        send_byte(ADDR_RD, a);
        chk("R1", "read address ack", {7'd0, a}, 8'd1);
        recv_byte(b, n > 0);
        chk(req, "count byte", b, m[8]);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            chk(req, $sformatf("read byte %0d", k), b, exp_rd(k));
        end
        stop_c();
        hw(4);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) m[i] = 8'h00;
        for (int i = 1; i <= 4; i++) m[i] = 8'hFF;
        m[6] = 8'hFF; m[8] = 8'h08; m[9] = 8'h10;
        chk("R8", "sda_oe after reset", {7'd0, sda_oe}, 8'd0);
        check_regs("R8 R10 R6");
    endtask

    task automatic t_write_basic();
        for (int i = 0; i < 24; i++) pat[i] = 8'h40 + 8'(i);
        pat[8] = 8'h05;
        wr_xfer(11, "R2 R6 R7");
    endtask

    task automatic t_read_limit();
        rd_xfer(8, "R3 R7");
    endtask

    task automatic t_count_zero();
        pat[8] = 8'h00;
        wr_xfer(9, "R4");
        chk("R4", "count register kept", regs[8*8 +: 8], 8'h05);
        pat[8] = 8'h05;
    endtask

    task automatic t_pairs();
        pat[11] = 8'h3C; pat[12] = 8'hC3; pat[13] = 8'h5A; pat[14] = 8'hA5;
        wr_xfer(12, "R5 half pair 11");
        chk("R5", "reg11 unchanged after half pair", regs[11*8 +: 8], 8'h00);
        wr_xfer(13, "R5 full pair 11");
        chk("R5", "reg12 committed", regs[12*8 +: 8], 8'hC3);
        wr_xfer(14, "R5 half pair 13");
        chk("R5", "reg13 unchanged after half pair", regs[13*8 +: 8], 8'h00);
        wr_xfer(15, "R5 full pair 13");
        chk("R5", "reg14 committed", regs[14*8 +: 8], 8'hA5);
    endtask

    task automatic t_nomatch();
        logic a;
        start_c();
        send_byte(8'hA0, a);
        chk("R1", "foreign address nack", {7'd0, a}, 8'd0);
        send_byte(8'h00, a);
        chk("R1", "following byte ignored", {7'd0, a}, 8'd0);
        send_byte(ADDR_WR, a);
        chk("R1", "address ignored until START", {7'd0, a}, 8'd0);
        stop_c();
        hw(4);
        check_regs("R1");
    endtask

    task automatic t_full_range();
        pat[8]  = 8'h19;
        pat[19] = 8'h99;
        pat[20] = 8'hAA;
        wr_xfer(23, "R2 R7");
        rd_xfer(23, "R3 R7");
    endtask

    task automatic t_early_nack();
        logic       a;
        logic [7:0] b;
        start_c();
        send_byte(ADDR_RD, a);
        recv_byte(b, 1'b0);
        chk("R3", "count byte before nack", b, m[8]);
        hw(4);
        chk("R3", "sda released after nack", {7'd0, sda_oe}, 8'd0);
        stop_c();
        hw(4);
        chk("R9", "sda released after stop", {7'd0, sda_oe}, 8'd0);
        rd_xfer(3, "R3 after early nack");
    endtask

    initial begin
        hw(5);
        rst = 1'b0;
        hw(5);
        t_reset();
        t_write_basic();
        t_read_limit();
        t_count_zero();
        t_pairs();
        t_nomatch();
        t_full_range();
        t_early_nack();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule